// File: doc/BRIEF.md
# Write-Protected Seconds Counter

A 32-bit clock that counts whole seconds from a system clock. A prescaler counts `CYC_PER_SEC` system cycles and then makes a one-cycle tick. Each tick adds one to the counter. Software reaches the counter through three 16-bit slots on a simple register bus. One slot holds the upper half, one holds the lower half, and one is a control slot that holds the write-enable flag.

The counter is guarded against stray writes. A write to either half takes effect only while the write-enable flag is set. Writing the lower half leaves the flag set. Writing the upper half clears it, so the usual update order is: arm, lower half, upper half. Every write that changes the counter also restarts the prescaler, so a full second passes before the next increment. While reset is held, the counter loads a seed value, or zero when the seed option is off.

Top module: `sec_counter_wp`

## Requirements
- R1: The counter increments by one at the edge that ends every CYC_PER_SEC-th system cycle after the last restart. It wraps from 0xFFFFFFFF to 0.
- R2: A read strobe at byte offset 0x0 returns counter bits 31:16, and at offset 0x4 returns bits 15:0. The data appears on the read port in the cycle after the strobe and holds until the next read. A write in the same cycle as the read does not affect the data returned.
- R3: Offset 0x8 always reads 0. A write there loads write-data bit 0 into the write-enable flag (1 = armed). Any offset other than 0x0, 0x4 and 0x8 reads 0, and writes to it change nothing.
- R4: While armed, a write to offset 0x4 replaces counter bits 15:0, keeps bits 31:16, and leaves the flag armed.
- R5: While armed, a write to offset 0x0 replaces counter bits 31:16, keeps bits 15:0, and disarms the flag.
- R6: While disarmed, writes to offsets 0x0 and 0x4 change neither the counter nor the prescaler phase.
- R7: A write that changes the counter restarts the prescaler. The next increment comes exactly CYC_PER_SEC cycles after that write's edge.
- R8: When an accepted counter write and a tick fall in the same cycle, the written value is stored and the tick adds nothing.
- R9: While reset is high, the counter takes seed_i (HAS_SEED=1) or 0 (HAS_SEED=0), the flag is disarmed and the prescaler is cleared. Counting starts over after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| seed_i | input | 32 | Value loaded into the counter during reset |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |

## Verification
Directed sequences try writes with the flag clear, lower-then-upper updates with the flag set, and a write after the flag has cleared itself. Together these separate the disarmed-ignore rule, the lower-keeps-armed rule and the upper-disarms rule. Idle runs that read the lower half every cycle place each increment in one exact cycle, both after reset and after a write. This catches any off-by-one in the prescaler or a missing restart. A write placed exactly on a tick cycle, a wrap from all ones, and a read paired with a write to the same slot test the collision order and the read timing. A long seeded random mix of reads, writes, arming and unmapped offsets is compared against a cycle-level model in the bench.

// File: rtl/seccnt_pkg.sv
package seccnt_pkg;

    // Byte offsets of the three slots; software depends on these values.
    localparam int unsigned OFF_HI  = 'h0;
    localparam int unsigned OFF_LO  = 'h4;
    localparam int unsigned OFF_CTL = 'h8;

    typedef enum logic [1:0] {
        SLOT_HI   = 2'd0,
        SLOT_LO   = 2'd1,
        SLOT_CTL  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic hi;
        logic lo;
        logic ctl;
    } strobe_t;

endpackage

// File: rtl/seccnt_decode.sv
module seccnt_decode
    import seccnt_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output slot_e             slot_o,
    output strobe_t           wr_o,
    output strobe_t           rd_o
);

    always_comb begin
        if (addr_i == ADDR_W'(OFF_HI)) begin
            slot_o = SLOT_HI;
        end else if (addr_i == ADDR_W'(OFF_LO)) begin
            slot_o = SLOT_LO;
        end else if (addr_i == ADDR_W'(OFF_CTL)) begin
            slot_o = SLOT_CTL;
        end else begin
            slot_o = SLOT_NONE;
        end
    end

    always_comb begin
        wr_o.hi  = wr_i && (slot_o == SLOT_HI);
        wr_o.lo  = wr_i && (slot_o == SLOT_LO);
        wr_o.ctl = wr_i && (slot_o == SLOT_CTL);
        rd_o.hi  = rd_i && (slot_o == SLOT_HI);
        rd_o.lo  = rd_i && (slot_o == SLOT_LO);
        rd_o.ctl = rd_i && (slot_o == SLOT_CTL);
    end

endmodule

// File: rtl/seccnt_prescaler.sv
module seccnt_prescaler #(
    parameter int unsigned CYC_PER_SEC = 100_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int unsigned PW = (CYC_PER_SEC > 2) ? $clog2(CYC_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_SEC - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } presc_state_t;

    presc_state_t st_d, st_q;

    assign tick_o = (st_q.phase == LAST);

    always_comb begin
        st_d = st_q;
        if (restart_i || tick_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/seccnt_core.sv
module seccnt_core
    import seccnt_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter bit          HAS_SEED = 1'b1,
    localparam int unsigned CNT_W   = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CNT_W-1:0]  seed_i,
    input  strobe_t           wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              armed_o,
    output logic              accept_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] reset_val;

    generate
        if (HAS_SEED) begin : g_seed
            assign reset_val = seed_i;
        end else begin : g_zero
            logic unused_seed;
            assign unused_seed = ^seed_i;
            assign reset_val   = '0;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        accept_o = 1'b0;
        if (wr_i.ctl) begin
            st_d.armed = wdata_i[0];
        end
        if (wr_i.lo && st_q.armed) begin
            st_d.cnt[DATA_W-1:0] = wdata_i;
            accept_o             = 1'b1;
        end
        if (wr_i.hi && st_q.armed) begin
            st_d.cnt[CNT_W-1:DATA_W] = wdata_i;
            st_d.armed               = 1'b0;
            accept_o                 = 1'b1;
        end
        if (!accept_o && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt   <= reset_val;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign armed_o = st_q.armed;

endmodule

// File: rtl/seccnt_readback.sv
module seccnt_readback
    import seccnt_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_i,
    input  strobe_t           rd_sel_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rb_state_t;

    rb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            if (rd_sel_i.hi) begin
                st_d.rdata = cnt_i[CNT_W-1:DATA_W];
            end else if (rd_sel_i.lo) begin
                st_d.rdata = cnt_i[DATA_W-1:0];
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/sec_counter_wp.sv
module sec_counter_wp
    import seccnt_pkg::*;
#(
    parameter int unsigned CYC_PER_SEC = 100_000_000,
    parameter int unsigned ADDR_W      = 4,
    parameter bit          HAS_SEED    = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [31:0]       seed_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o
);

    localparam int unsigned DATA_W = 16;
    localparam int unsigned CNT_W  = 2 * DATA_W;

    slot_e            slot;
    strobe_t          wr_sel;
    strobe_t          rd_sel;
    logic             tick;
    logic             accept;
    logic             armed;
    logic [CNT_W-1:0] cnt;

    seccnt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .wr_i   (bus_wr_i),
        .rd_i   (bus_rd_i),
        .slot_o (slot),
        .wr_o   (wr_sel),
        .rd_o   (rd_sel)
    );

    seccnt_prescaler #(.CYC_PER_SEC(CYC_PER_SEC)) u_presc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (accept),
        .tick_o    (tick)
    );

    seccnt_core #(.DATA_W(DATA_W), .HAS_SEED(HAS_SEED)) u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .seed_i   (seed_i),
        .wr_i     (wr_sel),
        .wdata_i  (bus_wdata_i),
        .tick_i   (tick),
        .cnt_o    (cnt),
        .armed_o  (armed),
        .accept_o (accept)
    );

    seccnt_readback #(.DATA_W(DATA_W)) u_rb (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rd_i     (bus_rd_i),
        .rd_sel_i (rd_sel),
        .cnt_i    (cnt),
        .rdata_o  (bus_rdata_o)
    );

    logic unused_slot;
    assign unused_slot = ^slot;

endmodule

// File: rtl/seccnt_checker.sv
module seccnt_checker #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [15:0]       bus_wdata_i,
    input logic [15:0]       bus_rdata_o,
    input logic [31:0]       cnt,
    input logic              armed,
    input logic              tick
);

    logic wr_hi, wr_lo, rd_ctl, hit;
    assign wr_hi  = bus_wr_i && (bus_addr_i == ADDR_W'('h0));
    assign wr_lo  = bus_wr_i && (bus_addr_i == ADDR_W'('h4));
    assign rd_ctl = bus_rd_i && (bus_addr_i == ADDR_W'('h8));
    assign hit    = (wr_hi || wr_lo) && armed;

    AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        tick && !hit |=> cnt == $past(cnt) + 32'd1);  // R1
    AST_CTL_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_ctl |=> bus_rdata_o == 16'h0);  // R3
    AST_LO_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_lo && armed |=> armed && cnt[15:0] == $past(bus_wdata_i));  // R4
    AST_HI_DISARMS: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_hi && armed |=> !armed && cnt[31:16] == $past(bus_wdata_i));  // R5
    AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_hi || wr_lo) && !armed && !tick |=> $stable(cnt));  // R6
    AST_WRITE_BEATS_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_lo && armed && tick |=> cnt[31:16] == $past(cnt[31:16]));  // R8

endmodule

bind sec_counter_wp seccnt_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt         (cnt),
    .armed       (armed),
    .tick        (tick)
);

// File: tb/sec_counter_wp_bench.sv
module sec_counter_wp_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [31:0] seed_i = 32'h1234_ABCD;
    logic [3:0]  bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_cnt;
    int          m_phase;
    bit          m_armed;

    sec_counter_wp #(.CYC_PER_SEC(CYC), .ADDR_W(4), .HAS_SEED(1'b1)) u_sec_counter_wp (
        .clk_i, .rst_i, .seed_i, .bus_addr_i, .bus_wr_i, .bus_rd_i,
        .bus_wdata_i, .bus_rdata_o
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic logic [15:0] exp_read(logic [3:0] a, logic [31:0] c);
        if (a == 4'h0) return c[31:16];
        if (a == 4'h4) return c[15:0];
        return 16'h0;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(bit wr, bit rd, logic [3:0] a, logic [15:0] wd, string tag);
        logic [15:0] er;
        bit tick, acc;
        bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = wd;
        er   = exp_read(a, m_cnt);
        tick = (m_phase == CYC - 1);
        acc  = 0;
        @(posedge clk_i);
        if (wr) begin
            if (a == 4'h0 && m_armed) begin m_cnt[31:16] = wd; m_armed = 0; acc = 1; end
            else if (a == 4'h4 && m_armed) begin m_cnt[15:0] = wd; acc = 1; end
            else if (a == 4'h8) m_armed = wd[0];
        end
        if (acc) m_phase = 0;
        else begin
            if (tick) m_cnt = m_cnt + 1;
            m_phase = tick ? 0 : m_phase + 1;
        end
        @(negedge clk_i);
        bus_wr_i = 0; bus_rd_i = 0;
        if (rd) check(tag, bus_rdata_o, er);
    endtask

    task automatic do_reset(logic [31:0] s);
        rst_i = 1; seed_i = s;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 0;
        m_cnt = s; m_phase = 0; m_armed = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        int n = 0;
        while (!done) begin
            @(posedge clk_i);
            n++;
            if (n > WATCHDOG) begin
                total++; bad++;
                $display("FAIL watchdog: got %0d cycles expected <= %0d", n, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));
        @(negedge clk_i);
        do_reset(32'h1234_ABCD);

        // R9 reset state, R2 read of both halves, R3 control slot reads zero
        step(0, 1, 4'h0, 0, "R9 hi");
        step(0, 1, 4'h4, 0, "R9 lo");
        step(0, 1, 4'h8, 0, "R3 ctl");

        // R1 counting exactly every CYC cycles
        for (int i = 0; i < 3 * CYC; i++) step(0, 1, 4'h4, 0, "R1 count");

        // R6 writes while disarmed
        step(1, 0, 4'h4, 16'hDEAD, "R6");
        step(1, 0, 4'h0, 16'hBEEF, "R6");
        step(0, 1, 4'h0, 0, "R6 hi");
        step(0, 1, 4'h4, 0, "R6 lo");

        // R4 lower writes keep arm, R5 upper write disarms
        step(1, 0, 4'h8, 16'h0001, "R3 arm");
        step(1, 0, 4'h4, 16'h1111, "R4");
        step(1, 0, 4'h4, 16'h2222, "R4");
        step(0, 1, 4'h4, 0, "R4 lo");
        step(1, 0, 4'h0, 16'h3333, "R5");
        step(0, 1, 4'h0, 0, "R5 hi");
        step(1, 0, 4'h4, 16'h4444, "R5 disarmed");
        step(0, 1, 4'h4, 0, "R5 lo after");

        // R7 restart of prescaler after a write
        step(1, 0, 4'h8, 16'h0001, "R3 arm");
        step(1, 0, 4'h4, 16'h0100, "R7");
        for (int i = 0; i < CYC + 2; i++) step(0, 1, 4'h4, 0, "R7 phase");

        // R1 wrap from all ones
        step(1, 0, 4'h8, 16'h0001, "R3 arm");
        step(1, 0, 4'h4, 16'hFFFF, "R1");
        step(1, 0, 4'h0, 16'hFFFF, "R1");
        for (int i = 0; i < CYC + 1; i++) step(0, 1, 4'h4, 0, "R1 wrap lo");
        step(0, 1, 4'h0, 0, "R1 wrap hi");

        // R8 write on the tick cycle
        step(1, 0, 4'h8, 16'h0001, "R3 arm");
        while (m_phase != CYC - 1) step(0, 0, 4'h0, 0, "idle");
        step(1, 0, 4'h4, 16'h5555, "R8");
        step(0, 1, 4'h4, 0, "R8 lo");
        step(0, 1, 4'h0, 0, "R8 hi");

        // R2 read together with a write to the same slot returns old data
        step(1, 1, 4'h4, 16'h7777, "R2 rd+wr");
        step(0, 1, 4'h4, 0, "R2 after");

        // R3 unmapped offset: reads zero, write has no effect; disarm via ctl bit 0
        step(1, 1, 4'hC, 16'hFFFF, "R3 unmapped");
        step(1, 0, 4'h8, 16'hFFFE, "R3 disarm");
        step(1, 0, 4'h0, 16'h9999, "R3");
        step(0, 1, 4'h0, 0, "R3 hi");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a;
            int unsigned r = $urandom % 8;
            a = (r < 3) ? 4'h4 : (r < 5) ? 4'h0 : (r < 7) ? 4'h8 : 4'h2;
            step(($urandom % 3) == 0, ($urandom % 2) == 0, a, 16'($urandom), "R2 random");
        end

        // R9 reset again with a new seed mid-run
        do_reset(32'h0000_FFFF);
        step(0, 1, 4'h4, 0, "R9 reseed lo");
        for (int i = 0; i < CYC; i++) step(0, 1, 4'h0, 0, "R9 reseed hi");

        done = 1;
        finish_run();
    end

endmodule